// File: doc/BRIEF.md
# I2C Master Register Front-End

This block is the register side of an I2C master controller, modelled at byte level. A host reaches five 8-bit registers through a simple request/acknowledge port: a data byte, control, status, own-address and a clock-divider value. The block does not generate SCL or SDA waveforms. It turns register activity into byte-level bus commands instead: start with an address byte, send a byte, receive a byte, and end the transfer. A separate bit engine carries these commands out and answers each one with an acknowledge result.

The first data-register write after a start is taken as the address byte. Bits 7:1 hold the target and bit 0 holds the read flag. Later writes send payload bytes. A data-register read returns the byte fetched earlier and starts the fetch of the next one. The block tracks whether a target address is open, keeps the bus-busy, received-NACK and interrupt flags, and drives a level interrupt. Clearing the enable bit while the block is enabled performs a soft reset. The soft reset keeps the own-address register.

A host access holds `reg_req` high until `reg_ack` pulses for one cycle, with read data valid in that cycle. It then drops `reg_req`. An access that needs the bus stalls until every bus command it issued has completed.

Top module: `i2c_reg_frontend`

## Requirements
- R1: After hardware reset every register reads 0x00 and `irq` is low.
- R2: The offsets are: own address 0, divider 1, control 2, status 3, data 4. Writes are masked: own address with 0xFE, divider with 0x3F, control with 0xFC. Control bits: enable 7, interrupt-enable 6, master 5, transmit 4, ack-select 3, restart 2. Status bits: busy 5, interrupt flag 1, received-NACK 0.
- R3: Offsets 5 to 7 read 0x00, and writes to them change no register.
- R4: A control write with bit 7 clear while enabled is a soft reset. Every register returns to 0x00 except own address, `irq` drops, and an open transfer is ended with an END command.
- R5: A normal control write copies the master bit into status busy. Clearing master while a transfer is open issues END and invalidates the address.
- R6: Writing restart as 1 while a transfer is open issues END and invalidates the address, and the restart bit reads back as 0.
- R7: In master mode with no open address, a data write issues START with that byte. An ACK clears received-NACK, opens the address and raises the interrupt. A NACK sets received-NACK and nothing else.
- R8: With an open address, a data write issues SEND. An ACK clears received-NACK and raises the interrupt. A NACK sets received-NACK, issues END and invalidates the address, so the next data write is a START.
- R9: A data read in master mode returns the byte held from earlier and reloads the hold register. The reload takes the received byte through RECV when the address is open and transmit is 0. It takes 0xFF when no address is open, when transmit is 1, or when the receive is NACKed. A successful receive raises the interrupt.
- R10: A data write while disabled issues no bus command.
- R11: The interrupt flag is set only when both enable and interrupt-enable are 1. `irq` mirrors the flag.
- R12: Writing a status byte with bit 1 clear clears the interrupt flag. No status write changes busy or received-NACK.
- R13: Bus command codes are START 0, SEND 1, RECV 2, END 3. The op and data stay stable while valid waits for ready, and the response is taken in the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Host access request, held until acknowledge |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_ack |
| reg_ack | output | 1 | One-cycle access completion |
| irq | output | 1 | Level interrupt |
| bus_cmd_valid | output | 1 | Bus command pending |
| bus_cmd_op | output | 2 | Command code |
| bus_cmd_data | output | 8 | Address or payload byte |
| bus_cmd_ready | input | 1 | Command completed this cycle |
| bus_rsp_nack | input | 1 | 1 when the command was not acknowledged |
| bus_rsp_data | input | 8 | Received byte for RECV |

## Verification
The bench builds the block with its default parameters: a 3-bit offset and the masks 0xFE, 0x3F and 0xFC. With a 3-bit offset, the unmapped offsets 5 to 7 are reachable. With these masks, writing 0xFF shows the masked bits at once. A modelled target acknowledges only address 0x50, NACKs the payload 0xEE, and can be told to fail receives. This brings every ACK and NACK path within reach: START, SEND and RECV, including the trailing END commands, the prefetch order of data reads, and the soft-reset, master-clear and restart cases.

// File: rtl/i2c_fe_pkg.sv
// Shared encodings for the I2C register front-end.
// Assumes 8-bit registers; offsets and bit positions are fixed by the register map.
package i2c_fe_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_END   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_PRIM, ST_TAIL, ST_DONE
    } fe_state_e;

    localparam int NUM_REGS = 5;
    localparam int REG_OWN  = 0;
    localparam int REG_DIV  = 1;
    localparam int REG_CTRL = 2;
    localparam int REG_STAT = 3;
    localparam int REG_DATA = 4;

    localparam int C_EN   = 7;
    localparam int C_IE   = 6;
    localparam int C_MST  = 5;
    localparam int C_TX   = 4;
    localparam int C_RSTA = 2;

    localparam int S_BUSY = 5;
    localparam int S_IF   = 1;
    localparam int S_RXAK = 0;
endpackage

// File: rtl/i2c_fe_decode.sv
// Offset decoder: one-hot select per register plus a hit flag.
// Assumes register i lives at offset i; offsets at or above NREGS miss.
module i2c_fe_decode #(
    parameter int ADDR_W = 3,
    parameter int NREGS  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREGS-1:0]  sel,
    output logic              hit
);
    // One comparator per mapped register.
    for (genvar i = 0; i < NREGS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end

    assign hit = |sel;
endmodule

// File: rtl/i2c_fe_bus_seq.sv
// Bus command sequencer: launches one command per start pulse, holds it
// until the bit engine signals ready, and returns the response as a done pulse.
// Assumes start is only pulsed while no command is pending.
module i2c_fe_bus_seq
    import i2c_fe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  bus_op_e       op_in,
    input  logic [DW-1:0] data_in,
    output logic          done,
    output logic          nack,
    output logic [DW-1:0] rdata,
    output logic          bus_valid,
    output bus_op_e       bus_op,
    output logic [DW-1:0] bus_data,
    input  logic          bus_ready,
    input  logic          bus_nack,
    input  logic [DW-1:0] bus_rdata
);
    // Command holding register and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_op    <= OP_END;
            bus_data  <= '0;
            done      <= 1'b0;
            nack      <= 1'b0;
            rdata     <= '0;
        end else begin
            done <= 1'b0;
            if (bus_valid) begin
                if (bus_ready) begin
                    bus_valid <= 1'b0;
                    done      <= 1'b1;
                    nack      <= bus_nack;
                    rdata     <= bus_rdata;
                end
            end else if (start) begin
                bus_valid <= 1'b1;
                bus_op    <= op_in;
                bus_data  <= data_in;
            end
        end
    end

    // R13
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_op) && $stable(bus_data)));

    // R13
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !bus_valid);
endmodule

// File: rtl/i2c_reg_frontend.sv
// I2C master register front-end: register decode, soft reset, flag handling
// and translation of data-register traffic into byte-level bus commands.
// Assumes the host holds reg_req until reg_ack and drops it the cycle after.
module i2c_reg_frontend
    import i2c_fe_pkg::*;
#(
    parameter int         ADDR_W    = 3,
    parameter logic [7:0] OWN_MASK  = 8'hFE,
    parameter logic [7:0] DIV_MASK  = 8'h3F,
    parameter logic [7:0] CTRL_MASK = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              reg_ack,
    output logic              irq,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd_op,
    output logic [7:0]        bus_cmd_data,
    input  logic              bus_cmd_ready,
    input  logic              bus_rsp_nack,
    input  logic [7:0]        bus_rsp_data
);
    localparam logic [7:0] RSTA_CLR = ~(8'h01 << C_RSTA);

    fe_state_e          state_q;
    logic [7:0]         own_q, div_q, ctrl_q, hold_q, rdata_q;
    logic               busy_q, if_q, rxak_q, open_q;
    bus_op_e            cur_op_q, seq_op_q, bus_op_w;
    logic               seq_start_q;
    logic [7:0]         seq_data_q;
    logic [NUM_REGS-1:0] sel;
    logic               hit;
    logic               seq_done, seq_nack;
    logic [7:0]         seq_rdata;
    logic [7:0]         stat_w, rd_mux;
    logic               irq_ok;

    i2c_fe_decode #(.ADDR_W(ADDR_W), .NREGS(NUM_REGS)) u_dec (
        .addr(reg_addr), .sel(sel), .hit(hit)
    );

    i2c_fe_bus_seq #(.DW(8)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start_q), .op_in(seq_op_q), .data_in(seq_data_q),
        .done(seq_done), .nack(seq_nack), .rdata(seq_rdata),
        .bus_valid(bus_cmd_valid), .bus_op(bus_op_w), .bus_data(bus_cmd_data),
        .bus_ready(bus_cmd_ready), .bus_nack(bus_rsp_nack), .bus_rdata(bus_rsp_data)
    );

    assign bus_cmd_op = bus_op_w;
    assign stat_w     = {2'b00, busy_q, 3'b000, if_q, rxak_q};
    assign irq_ok     = ctrl_q[C_EN] && ctrl_q[C_IE];
    assign irq        = if_q;
    assign reg_ack    = (state_q == ST_DONE);
    assign reg_rdata  = rdata_q;

    // Read multiplexer over the mapped registers.
    always_comb begin
        rd_mux = 8'h00;
        if (sel[REG_OWN])  rd_mux = own_q;
        if (sel[REG_DIV])  rd_mux = div_q;
        if (sel[REG_CTRL]) rd_mux = ctrl_q;
        if (sel[REG_STAT]) rd_mux = stat_w;
        if (sel[REG_DATA]) rd_mux = hold_q;
    end

    // Access sequencing, register updates and bus response handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            own_q       <= '0;
            div_q       <= '0;
            ctrl_q      <= '0;
            hold_q      <= '0;
            rdata_q     <= '0;
            busy_q      <= 1'b0;
            if_q        <= 1'b0;
            rxak_q      <= 1'b0;
            open_q      <= 1'b0;
            cur_op_q    <= OP_END;
            seq_op_q    <= OP_END;
            seq_start_q <= 1'b0;
            seq_data_q  <= '0;
        end else begin
            seq_start_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (reg_req) begin
                    state_q <= ST_DONE;
                    rdata_q <= reg_we ? 8'h00 : rd_mux;
                    if (reg_we) begin
                        if (sel[REG_OWN]) own_q <= reg_wdata & OWN_MASK;
                        if (sel[REG_DIV]) div_q <= reg_wdata & DIV_MASK;
                        if (sel[REG_STAT] && !reg_wdata[S_IF]) if_q <= 1'b0;
                        if (sel[REG_CTRL]) begin
                            if (ctrl_q[C_EN] && !reg_wdata[C_EN]) begin
                                div_q  <= '0;
                                ctrl_q <= '0;
                                hold_q <= '0;
                                busy_q <= 1'b0;
                                if_q   <= 1'b0;
                                rxak_q <= 1'b0;
                                open_q <= 1'b0;
                                if (open_q) begin
                                    seq_start_q <= 1'b1;
                                    seq_op_q    <= OP_END;
                                    seq_data_q  <= '0;
                                    state_q     <= ST_TAIL;
                                end
                            end else begin
                                ctrl_q <= reg_wdata & CTRL_MASK;
                                busy_q <= reg_wdata[C_MST];
                                if (open_q && (!reg_wdata[C_MST] || reg_wdata[C_RSTA])) begin
                                    ctrl_q      <= reg_wdata & CTRL_MASK & RSTA_CLR;
                                    open_q      <= 1'b0;
                                    seq_start_q <= 1'b1;
                                    seq_op_q    <= OP_END;
                                    seq_data_q  <= '0;
                                    state_q     <= ST_TAIL;
                                end
                            end
                        end
                        if (sel[REG_DATA] && ctrl_q[C_EN] && ctrl_q[C_MST]) begin
                            seq_start_q <= 1'b1;
                            seq_op_q    <= open_q ? OP_SEND : OP_START;
                            cur_op_q    <= open_q ? OP_SEND : OP_START;
                            seq_data_q  <= reg_wdata;
                            state_q     <= ST_PRIM;
                        end
                    end else if (sel[REG_DATA] && ctrl_q[C_MST]) begin
                        if (open_q && !ctrl_q[C_TX]) begin
                            seq_start_q <= 1'b1;
                            seq_op_q    <= OP_RECV;
                            cur_op_q    <= OP_RECV;
                            seq_data_q  <= '0;
                            state_q     <= ST_PRIM;
                        end else begin
                            hold_q <= 8'hFF;
                        end
                    end
                end
                ST_PRIM: if (seq_done) begin
                    state_q <= ST_DONE;
                    case (cur_op_q)
                        OP_START: begin
                            rxak_q <= seq_nack;
                            if (!seq_nack) begin
                                open_q <= 1'b1;
                                if (irq_ok) if_q <= 1'b1;
                            end
                        end
                        OP_SEND: begin
                            rxak_q <= seq_nack;
                            if (seq_nack) begin
                                open_q      <= 1'b0;
                                seq_start_q <= 1'b1;
                                seq_op_q    <= OP_END;
                                seq_data_q  <= '0;
                                state_q     <= ST_TAIL;
                            end else if (irq_ok) begin
                                if_q <= 1'b1;
                            end
                        end
                        default: begin
                            hold_q <= seq_nack ? 8'hFF : seq_rdata;
                            if (!seq_nack && irq_ok) if_q <= 1'b1;
                        end
                    endcase
                end
                ST_TAIL: if (seq_done) state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ctrl_q[C_EN] && ctrl_q[C_IE]));

    // R10
    disabled_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && reg_req && reg_we && sel[REG_DATA] && !ctrl_q[C_EN])
        |=> !seq_start_q);

    // R7
    start_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_op_w == OP_START) |-> ctrl_q[C_MST]);

    // R3
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && reg_req && !reg_we && !hit) |=> (reg_ack && reg_rdata == 8'h00));
endmodule

// File: tb/i2c_reg_frontend_test.sv
// Scoreboard bench: access tasks queue expected read data and bus commands;
// a monitor pops read expectations at each acknowledge.
module i2c_reg_frontend_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_req = 1'b0, reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       reg_ack, irq;
    logic       bus_cmd_valid;
    logic [1:0] bus_cmd_op;
    logic [7:0] bus_cmd_data;
    logic       bus_cmd_ready = 1'b0, bus_rsp_nack = 1'b0;
    logic [7:0] bus_rsp_data = '0;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] exp_rd_q[$];
    string      tag_rd_q[$];
    logic [9:0] op_log_q[$];
    logic [7:0] rx_val = 8'h11;
    bit         rx_fail = 0;
    bit         lat = 0;

    always #4 clk = ~clk;

    i2c_reg_frontend uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .irq(irq), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_op(bus_cmd_op), .bus_cmd_data(bus_cmd_data),
        .bus_cmd_ready(bus_cmd_ready), .bus_rsp_nack(bus_rsp_nack),
        .bus_rsp_data(bus_rsp_data)
    );

    task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Target model: ACKs address 0x50, NACKs payload 0xEE, one cycle latency.
    always @(negedge clk) begin
        if (bus_cmd_ready) begin
            bus_cmd_ready = 1'b0;
        end else if (bus_cmd_valid) begin
            if (!lat) lat = 1;
            else begin
                lat = 0;
                bus_rsp_nack = 1'b0;
                case (bus_cmd_op)
                    2'd0: bus_rsp_nack = (bus_cmd_data[7:1] != 7'h50);
                    2'd1: bus_rsp_nack = (bus_cmd_data == 8'hEE);
                    2'd2: begin
                        bus_rsp_nack = rx_fail;
                        bus_rsp_data = rx_val;
                        if (!rx_fail) rx_val = rx_val + 8'd1;
                    end
                    default: ;
                endcase
                op_log_q.push_back({bus_cmd_op, bus_cmd_data});
                bus_cmd_ready = 1'b1;
            end
        end
    end

    // Monitor: compare read data at each read acknowledge.
    always @(negedge clk) begin
        if (rst_n && reg_ack && !reg_we) begin
            if (exp_rd_q.size() == 0) chk("READ-SB", 8'h01, 8'h00);
            else chk(tag_rd_q.pop_front(), reg_rdata, exp_rd_q.pop_front());
        end
    end

    task automatic acc(input bit we, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; reg_req = 1'b1;
        do @(negedge clk); while (!reg_ack);
        reg_req = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string t);
        exp_rd_q.push_back(exp);
        tag_rd_q.push_back(t);
        acc(1'b0, a, 8'h00);
    endtask

    task automatic expect_op(input logic [1:0] op, input logic [7:0] d, input string t);
        logic [9:0] e;
        if (op_log_q.size() == 0) chk(t, 8'hEE, {6'd0, op});
        else begin
            e = op_log_q.pop_front();
            chk(t, {6'd0, e[9:8]}, {6'd0, op});
            chk(t, e[7:0], d);
        end
    endtask

    task automatic expect_none(input string t);
        chk(t, 8'(op_log_q.size()), 8'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(3'd0, 8'h00, "R1 own"); rd(3'd1, 8'h00, "R1 div");
        rd(3'd2, 8'h00, "R1 ctrl"); rd(3'd3, 8'h00, "R1 stat");
        rd(3'd4, 8'h00, "R1 data");
        // R5 busy follows master; R10 disabled data write ignored
        wr(3'd2, 8'h20); rd(3'd3, 8'h20, "R5 busy set");
        wr(3'd4, 8'hA0); expect_none("R10 no cmd");
        wr(3'd2, 8'h00); rd(3'd3, 8'h00, "R5 busy clr");
        // R2 masks
        wr(3'd0, 8'hFF); rd(3'd0, 8'hFE, "R2 own mask");
        wr(3'd1, 8'hFF); rd(3'd1, 8'h3F, "R2 div mask");
        wr(3'd2, 8'h83); rd(3'd2, 8'h80, "R2 ctrl mask");
        // R3 unmapped
        wr(3'd5, 8'h77); rd(3'd5, 8'h00, "R3 rd5"); rd(3'd7, 8'h00, "R3 rd7");
        rd(3'd0, 8'hFE, "R3 own kept"); rd(3'd1, 8'h3F, "R3 div kept");
        // R7 address ACK with interrupt
        wr(3'd2, 8'hF0); wr(3'd4, 8'hA0);
        expect_op(2'd0, 8'hA0, "R7 start");
        rd(3'd3, 8'h22, "R7 stat"); chk("R11 irq up", {7'd0, irq}, 8'h01);
        // R12 write-zero-to-clear
        wr(3'd3, 8'hFF); rd(3'd3, 8'h22, "R12 ones keep");
        wr(3'd3, 8'hFD); rd(3'd3, 8'h20, "R12 clear IF");
        chk("R12 irq low", {7'd0, irq}, 8'h00);
        // R8 send ACK then NACK
        wr(3'd4, 8'h3C); expect_op(2'd1, 8'h3C, "R8 send");
        rd(3'd3, 8'h22, "R8 send ack"); wr(3'd3, 8'h00);
        wr(3'd4, 8'hEE); expect_op(2'd1, 8'hEE, "R8 send nack");
        expect_op(2'd3, 8'h00, "R8 end"); rd(3'd3, 8'h21, "R8 rxak");
        wr(3'd4, 8'hA1); expect_op(2'd0, 8'hA1, "R8 restart addr");
        rd(3'd3, 8'h22, "R8 reopen"); wr(3'd3, 8'h00);
        // R9 receive prefetch
        wr(3'd2, 8'hE0); expect_none("R9 no end");
        rd(3'd4, 8'h00, "R9 first"); expect_op(2'd2, 8'h00, "R9 recv");
        rd(3'd4, 8'h11, "R9 second"); expect_op(2'd2, 8'h00, "R9 recv");
        rd(3'd3, 8'h22, "R9 irq flag");
        rx_fail = 1; rd(3'd4, 8'h12, "R9 third"); expect_op(2'd2, 8'h00, "R9 recv");
        rx_fail = 0; rd(3'd4, 8'hFF, "R9 fail FF"); expect_op(2'd2, 8'h00, "R9 recv");
        wr(3'd2, 8'hF0); rd(3'd4, 8'h13, "R9 tx held");
        rd(3'd4, 8'hFF, "R9 tx FF"); expect_none("R9 tx no cmd");
        wr(3'd3, 8'h00);
        // R6 restart
        wr(3'd2, 8'hF4); expect_op(2'd3, 8'h00, "R6 end");
        rd(3'd2, 8'hF0, "R6 selfclear");
        wr(3'd4, 8'hA0); expect_op(2'd0, 8'hA0, "R6 new start");
        // R5 master clear
        wr(3'd2, 8'hC0); expect_op(2'd3, 8'h00, "R5 end");
        rd(3'd3, 8'h02, "R5 busy off"); chk("R11 irq held", {7'd0, irq}, 8'h01);
        // R4 soft reset
        wr(3'd2, 8'hE0); wr(3'd4, 8'hA0); expect_op(2'd0, 8'hA0, "R4 start");
        wr(3'd2, 8'h00); expect_op(2'd3, 8'h00, "R4 end");
        rd(3'd2, 8'h00, "R4 ctrl"); rd(3'd3, 8'h00, "R4 stat");
        rd(3'd1, 8'h00, "R4 div"); rd(3'd0, 8'hFE, "R4 own kept");
        rd(3'd4, 8'h00, "R4 data"); chk("R4 irq", {7'd0, irq}, 8'h00);
        // R7 address NACK
        wr(3'd2, 8'hE0); wr(3'd4, 8'h42);
        expect_op(2'd0, 8'h42, "R7 nack start"); expect_none("R7 no end");
        rd(3'd3, 8'h21, "R7 nack stat"); chk("R7 irq", {7'd0, irq}, 8'h00);
        // R11 interrupt-enable off
        wr(3'd2, 8'hA0); wr(3'd4, 8'hA0); expect_op(2'd0, 8'hA0, "R11 start");
        rd(3'd3, 8'h20, "R11 no flag"); chk("R11 irq off", {7'd0, irq}, 8'h00);
        repeat (3) @(negedge clk);
        chk("READ-SB drained", 8'(exp_rd_q.size()), 8'd0);
        finish_run();
    end
endmodule